// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a per-core timer that raises an interrupt after a programmed number of prescaled ticks. It counts in two cascaded stages. A tick counter divides the input clock by reloading from a tick buffer. Each time the tick counter expires, an event counter steps once. When the event counter expires, the block sets a sticky interrupt status flag. The interrupt line is that flag gated by an enable bit.

Software reaches the block through a simple word-wide register port. Writes to the three timing registers are carried into the counting logic after a fixed transfer latency. Once a write has taken effect, the block sets a write-confirmation flag, which software clears by writing one to it.

The block runs in one of two modes:
- In one-shot mode the event counter stops after its first expiry.
- In interval mode the event counter reloads after every expiry and keeps firing until software clears the enables.

Top module: `ivl_tick_timer`

## Requirements
- R1: With tick buffer T and applied event count N, the status flag first reads 1 exactly SYNC_LAT + (N+1)*(T+1) clocks after the clock edge that accepts the starting control write. With T = 0 a tick occurs on every clock.
- R2: The event-count buffer is at address 1. Writing it loads a new count (bits 30:0) only when bit 31 of the written word is 1. With bit 31 at 0, the previously applied count stays in force.
- R3: The control register is at address 2. Its bits are: bit 0 runs the tick counter, bit 1 runs event counting, bit 2 selects interval mode. With bit 1 clear, no expiry occurs even while ticks run.
- R4: In interval mode (control 3'b111), expiries repeat every (N+1)*(T+1) clocks. In one-shot mode (control 3'b011), exactly one expiry occurs.
- R5: Bit 0 of the status register (address 4) is set on expiry and cleared by writing 1 to it.
- R6: The write-confirmation register is at address 5. Its bits 0, 1 and 3 report writes to the tick buffer, the event-count buffer and the control register. Each bit reads 1 from SYNC_LAT clocks after the write edge, and is cleared by writing 1 to it.
- R7: The `irq` output equals status bit 0 AND bit 0 of the enable register (address 3).
- R8: Clearing the run bits freezes both counters. Setting both run bits again reloads both counters from their buffers.
- R9: When an expiry and a write-one clear of the status bit happen in the same cycle, the status bit stays 1.
- R10: After reset, every register reads 0 and `irq` is 0.
- R11: A read of the tick buffer (address 0) or the event-count buffer returns the last word written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, combinational from addr |
| irq | output | 1 | Gated interrupt request |

## Verification
Each result falls due at a fixed cycle count from the edge that accepts a write:
- A write-confirmation bit is due SYNC_LAT edges after its write.
- The status flag is due SYNC_LAT + (N+1)*(T+1) edges after the starting control write, and again every (N+1)*(T+1) edges in interval mode.

The bench numbers every clock edge. For each expected expiry it queues the edge index at which `irq` must first be seen high. A monitor samples on the falling edge and compares each rise of `irq` against the head of that queue. Confirmation bits and frozen or gated states are read at exact edge offsets, one cycle before and at the due edge.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TBUF  = 3'd0,
    REG_IBUF  = 3'd1,
    REG_CTRL  = 3'd2,
    REG_IEN   = 3'd3,
    REG_ISTAT = 3'd4,
    REG_WSTAT = 3'd5
  } regSel_e;

  typedef struct packed {
    logic interval;
    logic intRun;
    logic tickRun;
  } ctrlBits_t;

  typedef struct packed {
    logic applyCtrl;
    logic applyIcnt;
    logic applyTick;
  } applyStrb_t;

  localparam int NUM_APPLY = 3;

endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_W   = 16,
  parameter int SYNC_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              expire,
  output applyStrb_t        strb,
  output logic [TICK_W-1:0] tickBuf,
  output logic [DATA_W-1:0] icntWord,
  output ctrlBits_t         ctrlReg,
  output logic              irq
);

  logic                 irqEn;
  logic                 irqStat;
  logic [NUM_APPLY-1:0] wstatVec;
  logic [NUM_APPLY-1:0] wrHit;
  logic [NUM_APPLY-1:0] applyVec;
  logic                 wrWstat;
  logic                 wrIstat;

  assign wrHit[0] = wrEn && (addr == REG_TBUF);
  assign wrHit[1] = wrEn && (addr == REG_IBUF);
  assign wrHit[2] = wrEn && (addr == REG_CTRL);
  assign wrWstat  = wrEn && (addr == REG_WSTAT);
  assign wrIstat  = wrEn && (addr == REG_ISTAT);

  // Software-visible buffers update at once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickBuf  <= '0;
      icntWord <= '0;
      ctrlReg  <= '0;
      irqEn    <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        REG_TBUF: tickBuf  <= wrData[TICK_W-1:0];
        REG_IBUF: icntWord <= wrData;
        REG_CTRL: ctrlReg  <= ctrlBits_t'(wrData[2:0]);
        REG_IEN:  irqEn    <= wrData[0];
        default: ;
      endcase
    end
  end

  // Transfer delay lines, one per timing register
  localparam int WSTAT_POS0 = 0;
  localparam int WSTAT_POS1 = 1;
  localparam int WSTAT_POS2 = 3;

  for (genvar k = 0; k < NUM_APPLY; k++) begin : g_xfer
    logic [SYNC_LAT-1:0] pipe;
    if (SYNC_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= wrHit[k];
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[SYNC_LAT-2:0], wrHit[k]};
      end
    end
    assign applyVec[k] = pipe[SYNC_LAT-1];

    localparam int POS = (k == 0) ? WSTAT_POS0 : (k == 1) ? WSTAT_POS1 : WSTAT_POS2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          wstatVec[k] <= 1'b0;
      else if (applyVec[k])               wstatVec[k] <= 1'b1;
      else if (wrWstat && wrData[POS])    wstatVec[k] <= 1'b0;
    end
  end

  assign strb.applyTick = applyVec[0];
  assign strb.applyIcnt = applyVec[1];
  assign strb.applyCtrl = applyVec[2];

  // Sticky status: a new expiry beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      irqStat <= 1'b0;
    else if (expire)                irqStat <= 1'b1;
    else if (wrIstat && wrData[0])  irqStat <= 1'b0;
  end

  assign irq = irqStat & irqEn;

  always_comb begin
    rdData = '0;
    case (addr)
      REG_TBUF:  rdData = DATA_W'(tickBuf);
      REG_IBUF:  rdData = icntWord;
      REG_CTRL:  rdData = DATA_W'(ctrlReg);
      REG_IEN:   rdData = DATA_W'(irqEn);
      REG_ISTAT: rdData = DATA_W'(irqStat);
      REG_WSTAT: rdData = DATA_W'({wstatVec[2], 1'b0, wstatVec[1], wstatVec[0]});
      default:   rdData = '0;
    endcase
  end

  AST_WSTAT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.applyCtrl |=> wstatVec[2]); // R6

  AST_WSTAT_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrWstat && wrData[0] && !strb.applyTick) |=> !wstatVec[0]); // R6

  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> irqStat); // R9

endmodule

// File: rtl/tt_count.sv
module tt_count
  import tt_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  applyStrb_t        strb,
  input  logic [TICK_W-1:0] tickBuf,
  input  logic [ICNT_W:0]   icntWord,
  input  ctrlBits_t         ctrlNext,
  output logic              expire
);

  logic [TICK_W-1:0] tickReload, tickCnt, tickRelNext;
  logic [ICNT_W-1:0] intReload, intCnt, intRelNext;
  ctrlBits_t         runCtrl;
  logic              done;
  logic              icntLoad, startNow, tickPulse, intStep;

  assign icntLoad    = strb.applyIcnt && icntWord[ICNT_W];
  assign tickRelNext = strb.applyTick ? tickBuf : tickReload;
  assign intRelNext  = icntLoad ? icntWord[ICNT_W-1:0] : intReload;
  assign startNow    = strb.applyCtrl && ctrlNext.tickRun && ctrlNext.intRun
                       && !(runCtrl.tickRun && runCtrl.intRun);
  assign tickPulse   = runCtrl.tickRun && (tickCnt == '0);
  assign intStep     = tickPulse && runCtrl.intRun && !done;
  assign expire      = intStep && (intCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickReload <= '0;
      intReload  <= '0;
      runCtrl    <= '0;
    end else begin
      tickReload <= tickRelNext;
      intReload  <= intRelNext;
      if (strb.applyCtrl) runCtrl <= ctrlNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      intCnt  <= '0;
      done    <= 1'b0;
    end else if (startNow) begin
      tickCnt <= tickRelNext;
      intCnt  <= intRelNext;
      done    <= 1'b0;
    end else begin
      if (runCtrl.tickRun)
        tickCnt <= tickPulse ? tickReload : tickCnt - 1'b1;
      if (icntLoad) begin
        intCnt <= icntWord[ICNT_W-1:0];
        done   <= 1'b0;
      end else if (intStep) begin
        if (intCnt == '0) begin
          if (runCtrl.interval) intCnt <= intReload;
          else                  done   <= 1'b1;
        end else begin
          intCnt <= intCnt - 1'b1;
        end
      end
    end
  end

  AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!runCtrl.tickRun && !strb.applyCtrl) |=> $stable(tickCnt)); // R8

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !runCtrl.interval && !strb.applyCtrl && !icntLoad) |=> !expire); // R4

endmodule

// File: rtl/ivl_tick_timer.sv
module ivl_tick_timer
  import tt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_W   = 16,
  parameter int SYNC_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int ICNT_W = DATA_W - 1;

  applyStrb_t        strb;
  logic [TICK_W-1:0] tickBuf;
  logic [DATA_W-1:0] icntWord;
  ctrlBits_t         ctrlReg;
  logic              expire;

  tt_regs #(.DATA_W(DATA_W), .TICK_W(TICK_W), .SYNC_LAT(SYNC_LAT)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .expire(expire), .strb(strb), .tickBuf(tickBuf),
    .icntWord(icntWord), .ctrlReg(ctrlReg), .irq(irq)
  );

  tt_count #(.TICK_W(TICK_W), .ICNT_W(ICNT_W)) i_count (
    .clk(clk), .rstN(rstN), .strb(strb), .tickBuf(tickBuf),
    .icntWord(icntWord), .ctrlNext(ctrlReg), .expire(expire)
  );

endmodule

// File: tb/test_ivl_tick_timer.sv
module test_ivl_tick_timer;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int lastWr = 0;
  int expQ[$];
  bit monOn = 1'b1;
  bit prevIrq = 1'b0;
  bit finished = 1'b0;

  ivl_tick_timer #(.DATA_W(32), .TICK_W(16), .SYNC_LAT(LAT)) i_ivl_tick_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1 lastWr = cyc;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitClear();
    while (irq !== 1'b1) @(negedge clk);
    wr(3'd4, 32'h1);
  endtask

  // Monitor: each rise of irq must match the head of the queue
  always @(negedge clk) begin
    if (rstN && monOn && irq && !prevIrq) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R4: actual unexpected irq at %0d expected none", cyc);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != cyc) begin
          mismatched++;
          $display("FAIL R1: actual irq at cycle %0d expected %0d", cyc, e);
        end
      end
    end
    prevIrq = irq;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R10", v, 32'h0);
    end
    check("R10", {31'b0, irq}, 32'h0);

    // R11 readback, R6 confirmation timing
    wr(3'd0, 32'h3);
    w = lastWr;
    rd(3'd5, v); check("R6", v & 32'h1, 32'h0);
    @(negedge clk); rd(3'd5, v); check("R6", v & 32'h1, 32'h0);
    @(negedge clk); rd(3'd5, v); check("R6", v & 32'h1, 32'h1);
    rd(3'd0, v); check("R11", v, 32'h3);
    wr(3'd5, 32'h1);
    rd(3'd5, v); check("R6", v, 32'h0);
    wr(3'd1, 32'h8000_0002);
    wr(3'd2, 32'h0);
    idle(3);
    rd(3'd5, v); check("R6", v, 32'hA);
    wr(3'd5, 32'hB);
    rd(3'd5, v); check("R6", v, 32'h0);

    // R4 interval mode: T=3 N=2 -> period 12
    wr(3'd3, 32'h1);
    wr(3'd2, 32'h7);
    expQ.push_back(lastWr + LAT + 12);
    expQ.push_back(lastWr + LAT + 24);
    expQ.push_back(lastWr + LAT + 36);
    for (int i = 0; i < 3; i++) waitClear();
    wr(3'd2, 32'h0);
    rd(3'd4, v); check("R5", v, 32'h0);

    // R4 one-shot
    wr(3'd2, 32'h3);
    expQ.push_back(lastWr + LAT + 12);
    waitClear();
    idle(40);
    rd(3'd4, v); check("R4", v, 32'h0);

    // R2 write without update bit keeps N=2
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h5);
    rd(3'd1, v); check("R11", v, 32'h5);
    wr(3'd2, 32'h3);
    expQ.push_back(lastWr + LAT + 12);
    waitClear();
    // R2 with update bit: N=1 -> 8
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h8000_0001);
    wr(3'd2, 32'h3);
    expQ.push_back(lastWr + LAT + 8);
    waitClear();

    // R8 freeze then reload
    wr(3'd2, 32'h0);
    wr(3'd2, 32'h3);
    idle(3);
    wr(3'd2, 32'h0);
    idle(30);
    rd(3'd4, v); check("R8", v, 32'h0);
    wr(3'd2, 32'h3);
    expQ.push_back(lastWr + LAT + 8);
    waitClear();

    // R3 ticks run, counting off
    wr(3'd2, 32'h0);
    wr(3'd2, 32'h1);
    idle(40);
    rd(3'd4, v); check("R3", v, 32'h0);
    wr(3'd2, 32'h3);
    expQ.push_back(lastWr + LAT + 8);
    waitClear();

    // R7 gating, R1 exact edge
    monOn = 1'b0;
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd2, 32'h3);
    w = lastWr;
    while (cyc < w + LAT + 8 - 1) @(negedge clk);
    rd(3'd4, v); check("R1", v, 32'h0);
    @(negedge clk);
    rd(3'd4, v); check("R1", v, 32'h1);
    check("R7", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h1);
    check("R7", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h1);
    check("R5", {31'b0, irq}, 32'h0);

    // R9 expiry every clock with T=0 N=0 beats clear
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h8000_0000);
    wr(3'd2, 32'h7);
    idle(6);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R9", v, 32'h1);
    wr(3'd2, 32'h0);
    idle(4);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R5", v, 32'h0);

    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R4: actual %0d pending expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule